// File: doc/BRIEF.md
# Oversampled Serial Receiver with Mute Wake-up

This block recovers asynchronous serial frames from a single RX line. It uses a baud tick that runs at sixteen times the bit rate, supplied from outside. Each frame has a low start bit, eight or nine data bits sent least significant bit first, and one high stop bit. When parity is on, the top data bit carries the parity. Every bit is decided by a majority vote over three ticks at the middle of the bit. A delivered frame is placed on `rx_data` and raises `rxne`. A parity mismatch raises `perr`. A line that stays high for a full frame time after a delivered frame raises `idle`. Each of the three flags drives `irq` only when its own enable is set, and a pulse on `ack` clears all three.

Software can put the receiver into a silent state with a write strobe. While the receiver is silent it keeps decoding the line but reports nothing. It returns to normal operation in one of two ways, chosen by `wake_addr`:

- An address frame that carries this node's address.
- An idle line lasting one frame time. This works only if a frame had been delivered before the silent state was entered.

In address mode, software cannot change the silent state while `rxne` is set.

Top module: `uart_rx_mute`

## Requirements
- R1: After reset `rxne`, `perr`, `idle`, `irq` and `muted` are all 0.
- R2: With `rx_en`=1, a frame is a 0 start bit, then N data bits least significant bit first, then a 1 stop bit. N is 9 when `nine_bit`=1 and 8 otherwise. The received bits appear on `rx_data` with bit 8 forced to 0 when N=8, and `rxne` rises. With `rx_en`=0 the line is ignored and `rxne` stays 0.
- R3: Each bit takes the majority of its samples at ticks 7, 8 and 9 of its 16 ticks. A start bit whose vote is 1 is dropped, so a low glitch shorter than 7 ticks delivers nothing.
- R4: With `par_en`=1, the top data bit is the parity bit. The XOR of all N received bits must equal `par_odd` (0 for even parity, 1 for odd parity). A mismatch sets `perr` together with `rxne`. With `par_en`=0, `perr` stays 0.
- R5: A one-cycle pulse on `ack` clears `rxne`, `perr` and `idle`.
- R6: After a delivered frame, if RX stays high for 16*(N+2) ticks, `idle` is set once.
- R7: `irq` is 1 exactly when at least one of these pairs is both set: (`rxne`, `ie_rxne`), (`perr`, `ie_perr`), (`idle`, `ie_idle`).
- R8: A pulse on `mute_wr` loads `mute_val` into `muted`. The write is ignored while `wake_addr`=1 and `rxne`=1.
- R9: While `muted`=1 no frame sets `rxne` or `perr`, and no idle period sets `idle`.
- R10: If `wake_addr`=1 and the receiver is muted, a frame is an address when its top data bit (bit 7 or bit 8) is 1. An address frame whose low ADDR_W bits equal `node_addr` clears `muted` and is delivered. Any other frame leaves the receiver muted.
- R11: If `wake_addr`=0 and the receiver is muted, 16*(N+2) ticks of high line clear `muted`, and later frames are delivered. This happens only if a frame had been delivered before `muted` went from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling tick, 16 per bit |
| rx | input | 1 | Serial line, asynchronous |
| rx_en | input | 1 | Receiver enable |
| nine_bit | input | 1 | 1: 9 data bits, 0: 8 data bits |
| par_en | input | 1 | Parity check enable |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| wake_addr | input | 1 | Wake source, 1: address frame, 0: idle line |
| node_addr | input | ADDR_W | Address of this node |
| mute_wr | input | 1 | Write strobe for the mute state |
| mute_val | input | 1 | Mute value loaded by `mute_wr` |
| ack | input | 1 | Clears all flags |
| ie_rxne | input | 1 | Data-ready interrupt enable |
| ie_perr | input | 1 | Parity-error interrupt enable |
| ie_idle | input | 1 | Idle interrupt enable |
| rx_data | output | 9 | Last delivered frame |
| rxne | output | 1 | Data-ready flag |
| perr | output | 1 | Parity-error flag |
| idle | output | 1 | Idle-line flag |
| muted | output | 1 | Silent state |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check on every cycle that:
- no flag rises while the receiver is muted;
- a parity error never stands without `rxne`;
- a blocked mute write leaves the receiver unmuted;
- `irq` stays low when every enable is clear;
- no frame is delivered while the receiver is disabled.

Other behaviours can only be shown by the bench's scenarios, which drive real frames:
- bit order and majority voting, including the rejected glitch;
- parity arithmetic in both widths;
- matching an address frame against `node_addr`;
- idle wake-up depending on whether a frame arrived before muting.

// File: rtl/uart_rx_mute.sv
module uart_rx_mute #(
  parameter int OSR    = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx,
  input  logic              rx_en,
  input  logic              nine_bit,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              wake_addr,
  input  logic [ADDR_W-1:0] node_addr,
  input  logic              mute_wr,
  input  logic              mute_val,
  input  logic              ack,
  input  logic              ie_rxne,
  input  logic              ie_perr,
  input  logic              ie_idle,
  output logic [8:0]        rx_data,
  output logic              rxne,
  output logic              perr,
  output logic              idle,
  output logic              muted,
  output logic              irq
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;
  localparam int IW  = $clog2(OSR * 11 + 1);
  localparam logic [IW-1:0] LIM8 = IW'(OSR * 10);
  localparam logic [IW-1:0] LIM9 = IW'(OSR * 11);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t           st;
  logic          rx_m, rx_s;
  logic [CW-1:0] tcnt;
  logic [3:0]    bcnt;
  logic [8:0]    shf;
  logic [2:0]    vote;
  logic [IW-1:0] icnt;
  logic          armed, seen, idle_ok;

  wire maj      = (vote[0] & vote[1]) | (vote[0] & vote[2]) | (vote[1] & vote[2]);
  wire bit_end  = os_tick && tcnt == CW'(OSR - 1);
  wire done     = os_tick && st == S_STOP && tcnt == CW'(MID + 1);
  wire [8:0] field = nine_bit ? shf : {1'b0, shf[8:1]};
  wire addr_hit = shf[8] && field[ADDR_W-1:0] == node_addr;
  wire par_bad  = par_en && ((^field) != par_odd);
  wire deliver  = done && (!muted || (wake_addr && addr_hit));
  wire [IW-1:0] lim = nine_bit ? LIM9 : LIM8;
  wire line_idle = rx_en && st == S_IDLE && rx_s;
  wire idle_hit = os_tick && line_idle && icnt == lim - 1'b1;

  assign irq = (rxne & ie_rxne) | (perr & ie_perr) | (idle & ie_idle);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rx;
      rx_s <= rx_m;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st   <= S_IDLE;
      tcnt <= '0;
      bcnt <= '0;
      shf  <= '0;
      vote <= '0;
    end else if (!rx_en) begin
      st <= S_IDLE;
    end else if (os_tick) begin
      tcnt <= (tcnt == CW'(OSR - 1)) ? '0 : tcnt + 1'b1;
      if (tcnt == CW'(MID - 1)) vote[0] <= rx_s;
      if (tcnt == CW'(MID))     vote[1] <= rx_s;
      if (tcnt == CW'(MID + 1)) vote[2] <= rx_s;
      case (st)
        S_IDLE:
          if (!rx_s) begin
            st   <= S_START;
            tcnt <= CW'(1);
          end
        S_START:
          if (bit_end) begin
            st   <= maj ? S_IDLE : S_DATA;
            bcnt <= '0;
          end
        S_DATA:
          if (bit_end) begin
            shf  <= {maj, shf[8:1]};
            bcnt <= bcnt + 1'b1;
            if (bcnt == (nine_bit ? 4'd8 : 4'd7)) st <= S_STOP;
          end
        S_STOP:
          if (tcnt == CW'(MID + 1)) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      icnt <= '0;
    else if (!line_idle)
      icnt <= '0;
    else if (os_tick && icnt != lim)
      icnt <= icnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_data <= '0;
      rxne    <= 1'b0;
      perr    <= 1'b0;
      idle    <= 1'b0;
      muted   <= 1'b0;
      armed   <= 1'b0;
      seen    <= 1'b0;
      idle_ok <= 1'b0;
    end else begin
      if (ack) begin
        rxne <= 1'b0;
        perr <= 1'b0;
        idle <= 1'b0;
      end
      if (deliver) begin
        rx_data <= field;
        rxne    <= 1'b1;
        perr    <= par_bad;
        armed   <= 1'b1;
        seen    <= 1'b1;
        muted   <= 1'b0;
      end
      if (idle_hit) begin
        if (!muted && armed) begin
          idle  <= 1'b1;
          armed <= 1'b0;
        end
        if (muted && !wake_addr && idle_ok) begin
          muted <= 1'b0;
          armed <= 1'b0;
        end
      end
      if (mute_wr && !(wake_addr && rxne)) begin
        muted <= mute_val;
        if (mute_val && !muted) idle_ok <= seen;
      end
    end
endmodule

// File: rtl/uart_rx_mute_chk.sv
module uart_rx_mute_chk #(
  parameter int OSR    = 16,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              par_en,
  input logic              wake_addr,
  input logic              mute_wr,
  input logic              ie_rxne,
  input logic              ie_perr,
  input logic              ie_idle,
  input logic              rxne,
  input logic              perr,
  input logic              idle,
  input logic              muted,
  input logic              irq
);
  AST_RXNE_UNMUTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxne) |-> !muted); // R9
  AST_IDLE_UNMUTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle) |-> !muted); // R9
  AST_PERR_NEEDS_PAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perr) |-> par_en); // R4
  AST_PERR_WITH_RXNE: assert property (@(posedge clk) disable iff (!rst_n)
    perr |-> rxne); // R4
  AST_MUTE_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_addr && rxne && mute_wr && !muted) |=> !muted); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_rxne && !ie_perr && !ie_idle) |-> !irq); // R7
  AST_OFF_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxne) |-> $past(rx_en)); // R2
endmodule

bind uart_rx_mute uart_rx_mute_chk #(.OSR(OSR), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/uart_rx_mute_tb.sv
module uart_rx_mute_tb;
  localparam int TDIV = 4;
  localparam int BITC = 16 * TDIV;

  logic clk = 0, rst_n = 0, os_tick = 0, rx = 1;
  logic rx_en = 0, nine_bit = 0, par_en = 0, par_odd = 0, wake_addr = 0;
  logic [3:0] node_addr = 4'h5;
  logic mute_wr = 0, mute_val = 0, ack = 0;
  logic ie_rxne = 0, ie_perr = 0, ie_idle = 0;
  logic [8:0] rx_data;
  logic rxne, perr, idle, muted, irq;
  int tests = 0, fails = 0;
  int dcnt = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) begin
    dcnt    <= (dcnt == TDIV - 1) ? 0 : dcnt + 1;
    os_tick <= (dcnt == TDIV - 1);
  end

  uart_rx_mute u_dut (.*);

  // nine_bit, par_en, par_odd, data[8:0]
  localparam logic [11:0] VEC [8] = '{
    {3'b000, 9'h0A5}, {3'b000, 9'h03C}, {3'b100, 9'h1C3}, {3'b010, 9'h0A5},
    {3'b010, 9'h0A4}, {3'b011, 9'h0A4}, {3'b111, 9'h100}, {3'b110, 9'h100}};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic [8:0] d, logic nine);
    @(negedge clk) rx = 0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      rx = d[i];
      repeat (BITC) @(negedge clk);
    end
    rx = 1;
    repeat (BITC + 10) @(negedge clk);
  endtask

  task automatic pulse_ack();
    @(negedge clk) ack = 1;
    @(negedge clk) ack = 0;
  endtask

  task automatic mute_write(logic v);
    @(negedge clk) begin mute_wr = 1; mute_val = v; end
    @(negedge clk) mute_wr = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R1 rxne", rxne, 0); check("R1 perr", perr, 0);
    check("R1 idle", idle, 0); check("R1 muted", muted, 0);
    check("R1 irq", irq, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    send(9'h0F0, 0);
    check("R2 disabled ignores line", rxne, 0);
    rx_en = 1;
    repeat (20) @(negedge clk);

    // R11: no frame before mute -> idle cannot wake
    wake_addr = 0;
    mute_write(1);
    check("R8 mute set", muted, 1);
    send(9'h033, 0);
    repeat (1500) @(negedge clk);
    check("R11 no wake without prior frame", muted, 1);
    check("R9 muted no rxne", rxne, 0);
    mute_write(0);
    check("R8 mute clear", muted, 0);

    foreach (VEC[k]) begin
      logic [8:0] d, exp;
      logic pe;
      {nine_bit, par_en, par_odd, d} = VEC[k];
      exp = nine_bit ? d : {1'b0, d[7:0]};
      pe  = par_en && ((^exp) != par_odd);
      send(d, nine_bit);
      check("R2 rxne", rxne, 1);
      check("R2 data", rx_data, exp);
      check("R4 parity", perr, pe);
      pulse_ack();
      check("R5 ack clears", {rxne, perr}, 0);
      repeat (800) @(negedge clk);
      pulse_ack();
    end
    nine_bit = 0; par_en = 0; par_odd = 0;

    // R3 glitch
    @(negedge clk) rx = 0;
    repeat (3 * TDIV) @(negedge clk);
    rx = 1;
    repeat (1200) @(negedge clk);
    check("R3 glitch rejected", rxne, 0);

    // R6 / R7
    send(9'h05A, 0);
    check("R7 irq masked", irq, 0);
    ie_rxne = 1; #1;
    check("R7 irq rxne", irq, 1);
    ie_rxne = 0;
    check("R6 idle not yet", idle, 0);
    repeat (700) @(negedge clk);
    check("R6 idle set", idle, 1);
    ie_idle = 1; #1;
    check("R7 irq idle", irq, 1);
    ie_idle = 0;
    pulse_ack();
    check("R5 idle cleared", idle, 0);
    repeat (1500) @(negedge clk);
    check("R6 idle once", idle, 0);

    // R11: wake by idle after a frame was seen, R9 no flags while muted
    mute_write(1);
    par_en = 1;
    send(9'h001, 0);
    check("R9 muted no rxne", rxne, 0);
    check("R9 muted no perr", perr, 0);
    par_en = 0;
    repeat (700) @(negedge clk);
    check("R11 idle wake", muted, 0);
    check("R9 no idle flag on wake", idle, 0);
    send(9'h066, 0);
    check("R11 delivered after wake", rx_data, 9'h066);
    pulse_ack();

    // R8 / R10 address wake
    wake_addr = 1;
    send(9'h011, 0);
    mute_write(1);
    check("R8 write ignored while rxne", muted, 0);
    pulse_ack();
    mute_write(1);
    check("R8 mute set after ack", muted, 1);
    send(9'h015, 0);
    check("R10 non-address stays muted", muted, 1);
    check("R10 non-address no rxne", rxne, 0);
    send(9'h093, 0);
    check("R10 wrong address stays muted", muted, 1);
    send(9'h095, 0);
    check("R10 matching address wakes", muted, 0);
    check("R10 address delivered", {rxne, rx_data}, {1'b1, 9'h095});
    pulse_ack();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule